// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the lookup path of a direct-mapped data cache whose set is chosen from address bits that paging never changes. The caller presents the word address within the page in the same cycle that a translation buffer supplies the physical page number and its valid flag. The line is read from the tag and data arrays while translation is still going on. The stored physical page number is then compared with the one the translation buffer delivers. One clock edge later the block reports hit or miss and the selected 32-bit word.

Each line holds a 128-bit block, a 20-bit physical page tag and a valid bit. With the defaults there are 256 lines, so capacity equals one 4 KB page. A fill port installs a whole line in one cycle, and a flush input invalidates every line. The design only works when the untranslated page-offset width covers both the index and the block offset. A parameter set that breaks this rule is rejected when the design is elaborated.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, hit and miss are low, the word output is zero, and every line is invalid, so any lookup misses.
- R2: When a lookup is made with the translation valid flag high, exactly one of hit and miss is high in the following cycle. Hit is high only when the addressed line is valid and its stored tag equals the incoming physical page number.
- R3: The line index is word-address bits [9:2], which are byte-address bits [11:4]. Word-address bits [1:0] choose word w of the block. Word w is fill data bits [32w+31:32w].
- R4: A hit loads the selected word onto the word output one cycle after the lookup. A miss leaves the word output unchanged.
- R5: While the translation valid flag is low, hit and miss are both low in the next cycle and the word output holds.
- R6: A fill writes block, tag and valid bit at its index in one cycle. A lookup to the same index in that same cycle sees the old contents. A lookup in a later cycle sees the new contents.
- R7: Flush clears every valid bit. A lookup in the flush cycle still sees the old state. A fill in the same cycle as a flush leaves its own line valid.
- R8: Lines are independent: writing one index, including the first (0) and last (255), leaves every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookupWordAddr | input | 10 | Untranslated word address within the page |
| ppn | input | 20 | Physical page number from the translation buffer |
| ppnValid | input | 1 | Translation valid; also requests the lookup |
| fillEn | input | 1 | Fill strobe |
| fillIndex | input | 8 | Line written by a fill |
| fillTag | input | 20 | Physical page number stored by a fill |
| fillData | input | 128 | Block stored by a fill |
| flush | input | 1 | Invalidate all lines |
| hit | output | 1 | Lookup hit, one cycle after the request |
| miss | output | 1 | Lookup miss, one cycle after the request |
| word | output | 32 | Selected word from the last hit |

## Verification
Every word position of a filled line is read back with a distinct value per word, so a wrong word select or a swapped word ordering is caught. Two kinds of lookup share an index but differ in page number: a matching tag, and a tag that differs in one bit. Together they separate a real tag compare from an index-only hit, and they show whether the word output holds on a miss. A fill and a lookup land on the same index in the same cycle, and a flush and a fill are issued together. These two cases fix the ordering of array updates against reads. Lookups with the translation flag low, and lines written at indices 0 and 255, confirm that the outputs stay quiet and that lines do not alias.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic doLookup;
    logic doFill;
    logic doFlush;
  } viptStrobe_t;
endpackage

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ppnValid,
  input  logic        fillEn,
  input  logic        flush,
  input  logic        matchRaw,
  output viptStrobe_t strobe,
  output logic        hit,
  output logic        miss
);
  always_comb begin
    strobe.doLookup = ppnValid;
    strobe.doFill   = fillEn;
    strobe.doFlush  = flush;
  end

  // Outcome registered one cycle after the request
  always_ff @(posedge clk) begin
    if (rst) begin
      hit  <= 1'b0;
      miss <= 1'b0;
    end else begin
      hit  <= strobe.doLookup && matchRaw;
      miss <= strobe.doLookup && !matchRaw;
    end
  end

  assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(hit && miss));
  assert_valid_gives_result_R2: assert property (@(posedge clk) disable iff (rst)
    ppnValid |=> (hit || miss));
  assert_quiet_when_untranslated_R5: assert property (@(posedge clk) disable iff (rst)
    !ppnValid |=> (!hit && !miss));
endmodule

// File: rtl/vipt_datapath.sv
module vipt_datapath
  import vipt_pkg::*;
#(
  parameter int LINE_COUNT = 256,
  parameter int BLOCK_W    = 128,
  parameter int WORD_W     = 32,
  parameter int PPN_W      = 20,
  parameter int IDX_W      = 8,
  parameter int WSEL_W     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  viptStrobe_t        strobe,
  input  logic [IDX_W-1:0]   lookupIdx,
  input  logic [WSEL_W-1:0]  wordSel,
  input  logic [PPN_W-1:0]   ppn,
  input  logic [IDX_W-1:0]   fillIndex,
  input  logic [PPN_W-1:0]   fillTag,
  input  logic [BLOCK_W-1:0] fillData,
  output logic               matchRaw,
  output logic [WORD_W-1:0]  word
);
  localparam int WORDS = BLOCK_W / WORD_W;

  logic [LINE_COUNT-1:0] validBits;
  logic [PPN_W-1:0]      tagMem  [LINE_COUNT];
  logic [BLOCK_W-1:0]    dataMem [LINE_COUNT];
  logic [BLOCK_W-1:0]    rdLine;
  logic [WORD_W-1:0]     blockWords [WORDS];

  // Array read from the untranslated index, in parallel with translation
  assign rdLine   = dataMem[lookupIdx];
  assign matchRaw = validBits[lookupIdx] && (tagMem[lookupIdx] == ppn);

  for (genvar w = 0; w < WORDS; w++) begin : g_words
    assign blockWords[w] = rdLine[w*WORD_W +: WORD_W];
  end

  // Valid bits: flush first, then fill, so a fill in the flush cycle survives
  always_ff @(posedge clk) begin
    if (rst) begin
      validBits <= '0;
    end else begin
      if (strobe.doFlush) validBits <= '0;
      if (strobe.doFill)  validBits[fillIndex] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doFill) begin
      tagMem[fillIndex]  <= fillTag;
      dataMem[fillIndex] <= fillData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (strobe.doLookup && matchRaw) begin
      word <= blockWords[wordSel];
    end
  end

  assert_fill_then_hit_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.doFill ##1 (strobe.doLookup && lookupIdx == $past(fillIndex) && ppn == $past(fillTag))
    |-> matchRaw);
  assert_flush_then_miss_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe.doFlush && !strobe.doFill) ##1 strobe.doLookup |-> !matchRaw);
  assert_word_holds_R4: assert property (@(posedge clk) disable iff (rst)
    !(strobe.doLookup && matchRaw) |=> $stable(word));
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int PAGE_OFF_W  = 12,
  parameter int LINE_COUNT  = 256,
  parameter int BLOCK_BYTES = 16,
  parameter int PADDR_W     = 32,
  parameter int WORD_W      = 32,
  localparam int IDX_W      = $clog2(LINE_COUNT),
  localparam int BOFF_W     = $clog2(BLOCK_BYTES),
  localparam int BYTE_W     = $clog2(WORD_W / 8),
  localparam int WSEL_W     = BOFF_W - BYTE_W,
  localparam int PPN_W      = PADDR_W - PAGE_OFF_W,
  localparam int BLOCK_W    = BLOCK_BYTES * 8,
  localparam int WADDR_W    = PAGE_OFF_W - BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WADDR_W-1:0] lookupWordAddr,
  input  logic [PPN_W-1:0]   ppn,
  input  logic               ppnValid,
  input  logic               fillEn,
  input  logic [IDX_W-1:0]   fillIndex,
  input  logic [PPN_W-1:0]   fillTag,
  input  logic [BLOCK_W-1:0] fillData,
  input  logic               flush,
  output logic               hit,
  output logic               miss,
  output logic [WORD_W-1:0]  word
);
  // Index and block offset must lie inside the untranslated page offset
  if (PAGE_OFF_W != IDX_W + BOFF_W) begin : g_geometry_bad
    $error("vipt_lookup: page offset must equal index plus block offset width");
  end

  viptStrobe_t strobe;
  logic        matchRaw;

  vipt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ppnValid (ppnValid),
    .fillEn   (fillEn),
    .flush    (flush),
    .matchRaw (matchRaw),
    .strobe   (strobe),
    .hit      (hit),
    .miss     (miss)
  );

  vipt_datapath #(
    .LINE_COUNT (LINE_COUNT),
    .BLOCK_W    (BLOCK_W),
    .WORD_W     (WORD_W),
    .PPN_W      (PPN_W),
    .IDX_W      (IDX_W),
    .WSEL_W     (WSEL_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .lookupIdx (lookupWordAddr[WSEL_W +: IDX_W]),
    .wordSel   (lookupWordAddr[WSEL_W-1:0]),
    .ppn       (ppn),
    .fillIndex (fillIndex),
    .fillTag   (fillTag),
    .fillData  (fillData),
    .matchRaw  (matchRaw),
    .word      (word)
  );
endmodule

// File: tb/vipt_lookup_bench.sv
`timescale 1ns/1ps
module vipt_lookup_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic [9:0]   lookupWordAddr;
  logic [19:0]  ppn;
  logic         ppnValid;
  logic         fillEn;
  logic [7:0]   fillIndex;
  logic [19:0]  fillTag;
  logic [127:0] fillData;
  logic         flush;
  logic         hit, miss;
  logic [31:0]  word;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vipt_lookup u_vipt_lookup (
    .clk(clk), .rst(rst), .lookupWordAddr(lookupWordAddr), .ppn(ppn),
    .ppnValid(ppnValid), .fillEn(fillEn), .fillIndex(fillIndex),
    .fillTag(fillTag), .fillData(fillData), .flush(flush),
    .hit(hit), .miss(miss), .word(word)
  );

  function automatic logic [127:0] mkBlock(input logic [31:0] seed);
    return {seed + 32'd3, seed + 32'd2, seed + 32'd1, seed};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    ppnValid = 0; fillEn = 0; flush = 0;
  endtask

  // Apply inputs away from the edge, then sample 2 ns after the next edge
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic doLookup(input logic [7:0] idx, input logic [1:0] ws, input logic [19:0] p);
    idle(); lookupWordAddr = {idx, ws}; ppn = p; ppnValid = 1; step();
  endtask

  task automatic doFill(input logic [7:0] idx, input logic [19:0] t, input logic [127:0] d);
    idle(); fillEn = 1; fillIndex = idx; fillTag = t; fillData = d; step();
  endtask

  task automatic expectOut(input string req, input logic h, input logic m, input logic [31:0] w);
    check(req, {31'd0, hit}, {31'd0, h});
    check(req, {31'd0, miss}, {31'd0, m});
    check(req, word, w);
  endtask

  task automatic testReset();
    check("R1 hit", {31'd0, hit}, 0);
    check("R1 miss", {31'd0, miss}, 0);
    check("R1 word", word, 0);
    doLookup(8'd5, 2'd0, 20'h00005);
    expectOut("R1 cold lookup", 0, 1, 0);
  endtask

  task automatic testWordSelect();
    doFill(8'h3C, 20'hABCDE, mkBlock(32'h1000_0000));
    for (int w = 0; w < 4; w++) begin
      doLookup(8'h3C, w[1:0], 20'hABCDE);
      expectOut("R3 R4 word select", 1, 0, 32'h1000_0000 + w);
    end
  endtask

  task automatic testTagMismatch();
    doLookup(8'h3C, 2'd1, 20'hABCDF);
    expectOut("R2 tag mismatch holds word", 0, 1, 32'h1000_0003);
  endtask

  task automatic testUntranslated();
    idle(); lookupWordAddr = {8'h3C, 2'd0}; ppn = 20'hABCDE; step();
    expectOut("R5 invalid translation", 0, 0, 32'h1000_0003);
  endtask

  task automatic testFillBypass();
    idle();
    fillEn = 1; fillIndex = 8'h77; fillTag = 20'h12345; fillData = mkBlock(32'h2000_0000);
    ppnValid = 1; lookupWordAddr = {8'h77, 2'd2}; ppn = 20'h12345;
    step();
    expectOut("R6 same-cycle fill sees old", 0, 1, 32'h1000_0003);
    doLookup(8'h77, 2'd2, 20'h12345);
    expectOut("R6 next cycle sees fill", 1, 0, 32'h2000_0002);
  endtask

  task automatic testEdges();
    doFill(8'h00, 20'h00001, mkBlock(32'h3000_0000));
    doFill(8'hFF, 20'h000FF, mkBlock(32'h4000_0000));
    doLookup(8'h00, 2'd3, 20'h00001);
    expectOut("R8 index 0", 1, 0, 32'h3000_0003);
    doLookup(8'hFF, 2'd0, 20'h000FF);
    expectOut("R8 index 255", 1, 0, 32'h4000_0000);
    doLookup(8'h3C, 2'd0, 20'hABCDE);
    expectOut("R8 other line intact", 1, 0, 32'h1000_0000);
  endtask

  task automatic testFlush();
    idle(); flush = 1; ppnValid = 1; lookupWordAddr = {8'h77, 2'd1}; ppn = 20'h12345;
    step();
    expectOut("R7 flush cycle sees old", 1, 0, 32'h2000_0001);
    doLookup(8'h77, 2'd1, 20'h12345);
    expectOut("R7 after flush miss", 0, 1, 32'h2000_0001);
    doLookup(8'h00, 2'd0, 20'h00001);
    expectOut("R7 index 0 flushed", 0, 1, 32'h2000_0001);
    idle(); flush = 1; fillEn = 1; fillIndex = 8'h10; fillTag = 20'h55555;
    fillData = mkBlock(32'h5000_0000); step();
    doLookup(8'h10, 2'd2, 20'h55555);
    expectOut("R7 fill wins over flush", 1, 0, 32'h5000_0002);
  endtask

  initial begin
    rst = 1; idle(); lookupWordAddr = 0; ppn = 0; fillIndex = 0; fillTag = 0; fillData = 0;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    #1;
    testReset();
    testWordSelect();
    testTagMismatch();
    testUntranslated();
    testFillBypass();
    testEdges();
    testFlush();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule